// File: doc/BRIEF.md
# Double-Precision FIR Multiply-Accumulate Engine

The engine produces one output of a TAPS-tap FIR filter for each input sample. Samples, coefficients and outputs are 64-bit two's-complement fractions with one sign bit and 63 fraction bits. A sample is offered on `in_valid_i`/`in_data_i` while `busy_o` is low. The engine stores it in a circular delay line, runs the filter, and raises `out_valid_o` for one cycle with the result on `out_data_o`. Coefficients are loaded through a write port that only takes effect while the engine is idle.

Every 64-bit operand is split into a signed upper half and an unsigned lower half. All arithmetic is done with 33x33-bit signed multipliers that feed two accumulators.

- **First pass.** Over all taps, the first pass sums the low-by-low products into the primary accumulator.
- **Second pass.**
  - The secondary accumulator starts from the primary sum shifted down one word. This carries the low-pass carries forward.
  - It then collects both cross products of every tap.
  - At the same time, the primary accumulator restarts and sums the high-by-high products.
- **Merge.** The secondary sum is realigned right by 31 bits across its words. It is then added to the doubled primary sum, low word first and then high word with the low word's carry-out.

The delay line and the coefficients sit in separate single-port memories, so one sample and one coefficient are fetched per cycle.

Top module: `fir64_engine`

## Requirements
- R1: After reset `out_valid_o` and `busy_o` are low and `out_data_o` is zero. Every delay-line slot and every coefficient is zero, so outputs are zero until coefficients are written.
- R2: A sample is accepted on a clock edge where `in_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle until the result appears.
- R3: `out_valid_o` goes high exactly 3*TAPS+2 clock edges after the accepting edge and stays high for one cycle only. `busy_o` falls on the same edge.
- R4: The result equals bits [126:63] of the exact sum over k = 0..TAPS-1 of c[k]*x[n-k]. Here x and c are the 64-bit operands read as signed integers, and the result wraps modulo 2^64.
- R5: The delay line holds the TAPS most recent accepted samples. Tap k uses the sample accepted k samples before the current one (k=0 is the current one). Slots not yet filled since reset read as zero, and a sample drops out once TAPS newer samples follow it.
- R6: With `busy_o` low, `coef_we_i` writes `coef_data_i` as coefficient c[`coef_addr_i`], which multiplies the tap-k sample for k = `coef_addr_i`.
- R7: A coefficient write presented while `busy_o` is high has no effect on any coefficient.
- R8: A coefficient write to an address of TAPS or above has no effect on any coefficient.
- R9: `in_valid_i` while `busy_o` is high is ignored: it neither enters the delay line nor produces another output.
- R10: `out_data_o` keeps its value in every cycle where `out_valid_o` is low.
- R11: Carries out of the summed low-by-low products and out of the low result word are propagated in full. The result stays exact (R4) when all lower halves are all ones and when both operands are the most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | New sample offered |
| in_data_i | input | DATA_W | Sample, 1.63 fraction |
| busy_o | output | 1 | Filter run in progress; samples and coefficient writes are not taken |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | AW | Tap index of the coefficient written |
| coef_data_i | input | DATA_W | Coefficient, 1.63 fraction |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | DATA_W | Filter result, 1.63 fraction |

## Verification
The bench builds the engine with TAPS=5 and DATA_W=64. Five taps is not a power of two, so the delay-line pointer has to wrap by comparison rather than by overflow. The 3-bit coefficient address also reaches the unused indices 5 to 7, which the R8 check writes to. The short line is refilled many times within the run, so samples visibly age out of the sum. Operand patterns include all-ones lower halves and the most negative value on both sides, which drive the low-pass carry and the wrap of the result.

// File: rtl/fir64_pkg.sv
package fir64_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_CROSS,
    ST_DRAIN,
    ST_MERGE
  } fsm_e;

  // which partial products the data returning this cycle feeds
  typedef enum logic [1:0] {
    PH_NONE,
    PH_LOW,
    PH_HI_A,
    PH_HI_B
  } phase_e;

  typedef struct packed {
    phase_e ph;
    logic   first;
  } tap_tag_t;

  typedef enum logic [1:0] {
    MAC_HOLD,
    MAC_LOAD,
    MAC_ADD
  } mac_op_e;

endpackage

// File: rtl/fir64_sp_mem.sv
module fir64_sp_mem #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rdata_q;
  logic         in_range;

  assign in_range = (32'(addr_i) < DEPTH);

  // one register row per entry; an address past DEPTH matches no row
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (en_i && we_i && (addr_i == AW'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (en_i && !we_i && in_range) begin
      rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/fir64_ctrl.sv
module fir64_ctrl
  import fir64_pkg::*;
#(
  parameter int TAPS = 8,
  parameter int AW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          busy_o,
  output logic          line_en_o,
  output logic          line_we_o,
  output logic [AW-1:0] line_addr_o,
  output logic          coef_rd_o,
  output logic [AW-1:0] coef_addr_o,
  output tap_tag_t      tag_o,
  output logic          merge_o
);

  localparam int CNT_W = $clog2(2 * TAPS + 1);
  localparam logic [CNT_W-1:0] LAST_LOW   = CNT_W'(TAPS - 1);
  localparam logic [CNT_W-1:0] LAST_CROSS = CNT_W'(2 * TAPS - 1);
  localparam logic [AW:0]      TAPS_X     = (AW + 1)'(TAPS);
  localparam logic [AW-1:0]    LAST_SLOT  = AW'(TAPS - 1);

  fsm_e             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  tap_tag_t         tag_q, tag_d;
  logic [AW-1:0]    tap;
  logic [AW:0]      back_raw, back;

  // tap index; the cross pass spends two cycles per tap
  assign tap = (state_q == ST_CROSS) ? AW'(cnt_q >> 1) : AW'(cnt_q);

  // slot holding the sample tap steps older than the newest
  always_comb begin
    back_raw = {1'b0, wr_ptr_q} + TAPS_X - {1'b0, tap};
    back     = (back_raw >= TAPS_X) ? back_raw - TAPS_X : back_raw;
  end

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    wr_ptr_d    = wr_ptr_q;
    line_en_o   = 1'b0;
    line_we_o   = 1'b0;
    line_addr_o = back[AW-1:0];
    coef_rd_o   = 1'b0;
    tag_d       = '{ph: PH_NONE, first: 1'b0};
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid_i) begin
          line_en_o   = 1'b1;
          line_we_o   = 1'b1;
          line_addr_o = wr_ptr_q;
          cnt_d       = '0;
          state_d     = ST_LOW;
        end
      end
      ST_LOW: begin
        line_en_o = 1'b1;
        coef_rd_o = 1'b1;
        tag_d     = '{ph: PH_LOW, first: (cnt_q == '0)};
        if (cnt_q == LAST_LOW) begin
          cnt_d   = '0;
          state_d = ST_CROSS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CROSS: begin
        // fetch on the even cycle, memory output is held for the odd one
        line_en_o = !cnt_q[0];
        coef_rd_o = !cnt_q[0];
        tag_d     = '{ph: (cnt_q[0] ? PH_HI_B : PH_HI_A), first: (cnt_q == '0)};
        if (cnt_q == LAST_CROSS) begin
          state_d = ST_DRAIN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DRAIN: state_d = ST_MERGE;
      ST_MERGE: begin
        state_d  = ST_IDLE;
        wr_ptr_d = (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      wr_ptr_q <= '0;
      tag_q    <= '{ph: PH_NONE, first: 1'b0};
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      wr_ptr_q <= wr_ptr_d;
      tag_q    <= tag_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign merge_o     = (state_q == ST_MERGE);
  assign coef_addr_o = tap;
  assign tag_o       = tag_q;

endmodule

// File: rtl/fir64_mac.sv
module fir64_mac
  import fir64_pkg::*;
#(
  parameter int OP_W  = 33,
  parameter int ACC_W = 96
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  mac_op_e                op_i,
  input  logic signed [OP_W-1:0] a_i,
  input  logic signed [OP_W-1:0] b_i,
  input  logic [ACC_W-1:0]       base_i,
  output logic [ACC_W-1:0]       acc_o
);

  localparam int PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_x, acc_q, acc_d;

  assign prod   = a_i * b_i;
  assign prod_x = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

  always_comb begin
    unique case (op_i)
      MAC_LOAD: acc_d = base_i + prod_x;
      MAC_ADD:  acc_d = acc_q + prod_x;
      default:  acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/fir64_merge.sv
module fir64_merge #(
  parameter int DATA_W = 64,
  parameter int ACC_W  = 96
) (
  input  logic [ACC_W-1:0]  pri_i,
  input  logic [ACC_W-1:0]  sec_i,
  output logic [DATA_W-1:0] y_o
);

  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] s_w [3];
  logic [HALF_W-1:0] r_lo, r_hi, p_lo, p_hi, y_hi;
  logic [HALF_W:0]   lo_sum;

  for (genvar g = 0; g < 3; g++) begin : g_word
    assign s_w[g] = sec_i[g*HALF_W +: HALF_W];
  end

  // secondary realigned right by HALF_W-1 across its words
  assign r_lo = {s_w[1][HALF_W-2:0], s_w[0][HALF_W-1]};
  assign r_hi = {s_w[2][HALF_W-2:0], s_w[1][HALF_W-1]};

  // primary doubled: fractional product alignment
  assign p_lo = {pri_i[HALF_W-2:0], 1'b0};
  assign p_hi = pri_i[DATA_W-2:HALF_W-1];

  assign lo_sum = {1'b0, p_lo} + {1'b0, r_lo};
  assign y_hi   = p_hi + r_hi + {{(HALF_W-1){1'b0}}, lo_sum[HALF_W]};
  assign y_o    = {y_hi, lo_sum[HALF_W-1:0]};

endmodule

// File: rtl/fir64_engine.sv
module fir64_engine
  import fir64_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 64,
  parameter int AW     = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              busy_o,
  input  logic              coef_we_i,
  input  logic [AW-1:0]     coef_addr_i,
  input  logic [DATA_W-1:0] coef_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);

  localparam int HALF_W = DATA_W / 2;
  localparam int OP_W   = HALF_W + 1;
  localparam int ACC_W  = 3 * HALF_W;

  logic              busy;
  logic              line_en, line_we, coef_rd, merge;
  logic [AW-1:0]     line_addr, coef_rd_addr;
  tap_tag_t          tag;
  logic [DATA_W-1:0] line_rd, coef_q;
  logic              cmem_en, cmem_we;
  logic [AW-1:0]     cmem_addr;

  fir64_ctrl #(.TAPS(TAPS), .AW(AW)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .busy_o     (busy),
    .line_en_o  (line_en),
    .line_we_o  (line_we),
    .line_addr_o(line_addr),
    .coef_rd_o  (coef_rd),
    .coef_addr_o(coef_rd_addr),
    .tag_o      (tag),
    .merge_o    (merge)
  );

  fir64_sp_mem #(.W(DATA_W), .DEPTH(TAPS), .AW(AW)) line_mem_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (line_en),
    .we_i   (line_we),
    .addr_i (line_addr),
    .wdata_i(in_data_i),
    .rdata_o(line_rd)
  );

  // coefficient port: host writes only while idle
  assign cmem_we   = coef_we_i && !busy;
  assign cmem_en   = coef_rd || cmem_we;
  assign cmem_addr = busy ? coef_rd_addr : coef_addr_i;

  fir64_sp_mem #(.W(DATA_W), .DEPTH(TAPS), .AW(AW)) coef_mem_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cmem_en),
    .we_i   (cmem_we),
    .addr_i (cmem_addr),
    .wdata_i(coef_data_i),
    .rdata_o(coef_q)
  );

  logic [HALF_W-1:0]     xh, xl, ch, cl;
  logic signed [OP_W-1:0] xh_s, xl_u, ch_s, cl_u;
  logic signed [OP_W-1:0] pa, pb, sa, sb;
  mac_op_e               pop, sop;
  logic [ACC_W-1:0]      pri_acc, sec_acc, sec_base;
  logic [DATA_W-1:0]     merged;

  assign {xh, xl} = line_rd;
  assign {ch, cl} = coef_q;
  assign xh_s     = $signed({xh[HALF_W-1], xh});
  assign ch_s     = $signed({ch[HALF_W-1], ch});
  assign xl_u     = $signed({1'b0, xl});
  assign cl_u     = $signed({1'b0, cl});

  // low-pass sum moved down one word seeds the cross sum
  assign sec_base = pri_acc >> HALF_W;

  always_comb begin
    pop = MAC_HOLD;
    sop = MAC_HOLD;
    pa  = xl_u;
    pb  = cl_u;
    sa  = xh_s;
    sb  = cl_u;
    unique case (tag.ph)
      PH_LOW: begin
        pop = tag.first ? MAC_LOAD : MAC_ADD;
      end
      PH_HI_A: begin
        pop = tag.first ? MAC_LOAD : MAC_ADD;
        sop = tag.first ? MAC_LOAD : MAC_ADD;
        pa  = xh_s;
        pb  = ch_s;
      end
      PH_HI_B: begin
        sop = MAC_ADD;
        sa  = xl_u;
        sb  = ch_s;
      end
      default: ;
    endcase
  end

  fir64_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) pri_mac_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (pop),
    .a_i   (pa),
    .b_i   (pb),
    .base_i('0),
    .acc_o (pri_acc)
  );

  fir64_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) sec_mac_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (sop),
    .a_i   (sa),
    .b_i   (sb),
    .base_i(sec_base),
    .acc_o (sec_acc)
  );

  fir64_merge #(.DATA_W(DATA_W), .ACC_W(ACC_W)) merge_i (
    .pri_i(pri_acc),
    .sec_i(sec_acc),
    .y_o  (merged)
  );

  logic              out_valid_q;
  logic [DATA_W-1:0] out_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= merge;
      if (merge) out_data_q <= merged;
    end
  end

  assign busy_o      = busy;
  assign out_valid_o = out_valid_q;
  assign out_data_o  = out_data_q;

endmodule

// File: rtl/fir64_engine_chk.sv
module fir64_engine_chk #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              busy_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o
);

  localparam logic [31:0] RUN_LEN = 32'(3 * TAPS + 3);

  logic [31:0] run_q;

  // cycles since the accepting edge, counted while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= '0;
    else if (in_valid_i && !busy_o)  run_q <= 32'd1;
    else if (busy_o)                 run_q <= run_q + 32'd1;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R1: assert (!out_valid_o && !busy_o && (out_data_o == '0));
    end
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !busy_o) |=> busy_o);

  assert_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> out_valid_o);

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !busy_o);

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (run_q == RUN_LEN));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));

endmodule

bind fir64_engine fir64_engine_chk #(.TAPS(TAPS), .DATA_W(DATA_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .busy_o     (busy_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o)
);

// File: tb/fir64_engine_tb_top.sv
module fir64_engine_tb_top;

  localparam int TAPS = 5;
  localparam int DW   = 64;
  localparam int AW   = 3;
  localparam int LAT  = 3 * TAPS + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          busy;
  logic          coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [DW-1:0] coef_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  fir64_engine #(.TAPS(TAPS), .DATA_W(DW), .AW(AW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .busy_o     (busy),
    .coef_we_i  (coef_we),
    .coef_addr_i(coef_addr),
    .coef_data_i(coef_data),
    .out_valid_o(out_valid),
    .out_data_o (out_data)
  );

  int            total = 0;
  int            bad = 0;
  logic [DW-1:0] m_coef [TAPS];
  logic [DW-1:0] m_hist [TAPS];
  logic [DW-1:0] last_y;

  function automatic logic [DW-1:0] rand64();
    return {$urandom(), $urandom()};
  endfunction

  // exact sum of products, then the 1.63 window
  function automatic logic [DW-1:0] model_y();
    logic signed [191:0] s, a, b;
    s = '0;
    for (int k = 0; k < TAPS; k++) begin
      a = $signed(m_hist[k]);
      b = $signed(m_coef[k]);
      s = s + a * b;
    end
    return s[126:63];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcoef(input int k, input logic [DW-1:0] v, input bit applies);
    @(negedge clk);
    while (busy) @(negedge clk);
    coef_we   = 1'b1;
    coef_addr = AW'(k);
    coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    if (applies) m_coef[k] = v;
  endtask

  // junk: in_valid during busy; cwr: coefficient write during busy
  task automatic push(input logic [DW-1:0] x, input string req, input bit junk, input bit cwr);
    logic [DW-1:0] exp;
    int            k;
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = TAPS - 1; j > 0; j--) m_hist[j] = m_hist[j-1];
    m_hist[0] = x;
    exp = model_y();
    check("R2 busy after accept", {63'd0, busy}, 64'd1);
    k = 0;
    while (!out_valid && k < 200) begin
      if (junk && k == 3) begin
        in_valid = 1'b1;
        in_data  = rand64();
      end
      if (junk && k == 5) in_valid = 1'b0;
      if (cwr && k == 4) begin
        coef_we   = 1'b1;
        coef_addr = '0;
        coef_data = ~m_coef[0];
      end
      if (cwr && k == 5) coef_we = 1'b0;
      @(negedge clk);
      k++;
    end
    check("R3 latency", 64'(k), 64'(LAT));
    check(req, out_data, exp);
    last_y = exp;
    @(negedge clk);
    check("R3 single pulse", {62'd0, out_valid, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd715));
    for (int k = 0; k < TAPS; k++) begin
      m_coef[k] = '0;
      m_hist[k] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset valid/busy", {62'd0, out_valid, busy}, 64'd0);
    check("R1 reset data", out_data, '0);
    rst_n = 1'b1;

    // R1: zero coefficients after reset give zero
    push(rand64(), "R1 zero coefs", 1'b0, 1'b0);
    push(64'h7FFF_FFFF_FFFF_FFFF, "R1 zero coefs max", 1'b0, 1'b0);

    // R6: one tap selects a single aged sample
    wcoef(2, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
    for (int i = 0; i < 4; i++) push(rand64(), "R6 tap order", 1'b0, 1'b0);
    wcoef(2, '0, 1'b1);
    wcoef(TAPS - 1, 64'h4000_0000_0000_0000, 1'b1);
    // R5: oldest tap, then ages out over wraps
    for (int i = 0; i < 2 * TAPS + 1; i++) push(rand64(), "R5 circular line", 1'b0, 1'b0);

    for (int k = 0; k < TAPS; k++) wcoef(k, rand64(), 1'b1);
    for (int i = 0; i < 8; i++) push(rand64(), "R4 random", 1'b0, 1'b0);

    // R11 carry corners
    for (int k = 0; k < TAPS; k++) wcoef(k, 64'h0000_0000_FFFF_FFFF, 1'b1);
    for (int i = 0; i < TAPS + 1; i++) push(64'h0000_0000_FFFF_FFFF, "R11 low ones", 1'b0, 1'b0);
    for (int k = 0; k < TAPS; k++) wcoef(k, 64'h8000_0000_0000_0000, 1'b1);
    for (int i = 0; i < TAPS; i++) push(64'h8000_0000_0000_0000, "R11 min by min", 1'b0, 1'b0);
    push(64'hFFFF_FFFF_FFFF_FFFF, "R11 min by -lsb", 1'b0, 1'b0);
    for (int k = 0; k < TAPS; k++) wcoef(k, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
    for (int i = 0; i < TAPS; i++) push(64'hFFFF_FFFF_FFFF_FFFF, "R11 max by -lsb", 1'b0, 1'b0);

    for (int k = 0; k < TAPS; k++) wcoef(k, rand64(), 1'b1);
    // R8: addresses past the last tap
    for (int a = TAPS; a < (1 << AW); a++) wcoef(a, rand64(), 1'b0);
    for (int i = 0; i < 3; i++) push(rand64(), "R8 out-of-range coef write", 1'b0, 1'b0);

    // R7: write while busy must not land
    push(rand64(), "R4 before busy write", 1'b0, 1'b1);
    push(rand64(), "R7 busy coef write ignored", 1'b0, 1'b0);

    // R9: in_valid during busy
    push(rand64(), "R4 before busy sample", 1'b1, 1'b0);
    begin
      int pulses = 0;
      for (int i = 0; i < LAT + 4; i++) begin
        @(negedge clk);
        if (out_valid) pulses++;
        // R10: data holds between strobes
        check("R10 hold", out_data, last_y);
      end
      check("R9 no extra output", 64'(pulses), 64'd0);
    end
    push(rand64(), "R9 busy sample ignored", 1'b0, 1'b0);

    for (int i = 0; i < 30; i++) begin
      if (($urandom() & 32'd3) == 0) wcoef(int'($urandom() % TAPS), rand64(), 1'b1);
      push(rand64(), "R4 random", 1'b0, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule